// File: doc/BRIEF.md
# Phase/Frequency Detector with Drive Override

This block compares a reference pulse train with the pulse train coming back from a feedback divider. It responds to both phase and frequency error. A rising edge on the reference raises an up flag, and a rising edge on the feedback raises a down flag. Once both flags are up, both drop on the next clock. The two flags are turned into a three-state charge-pump command: drive high, drive low, or release the line (high impedance).

A three-bit mode word sits in front of that command. It can pass the detector through, release the line, or pin the output high or low for loop test and calibration. Both pulse inputs are synchronised into the block clock before their edges are detected. The mode word is taken as a quasi-static control value and is not synchronised.

Top module: `pfd_ctl`

## Requirements
- R1: While `rst_ni` is low, `up_o` and `dn_o` are 0. After reset, with mode 000 and no edges, `drive_en_o` is 0.
- R2: In a pass-through mode, a rising edge on `ref_i` sets `up_o` exactly SYNC_STAGES+1 clocks after the input changes. `up_o` stays set until it is cleared. A level held high does not set it again.
- R3: In a pass-through mode, a rising edge on `fb_i` sets `dn_o` with the same latency and hold behaviour as R2.
- R4: When `up_o` and `dn_o` are both 1, both are 0 after the next clock. An edge that arrives in that same cycle is dropped.
- R5: In a pass-through mode, the drive pair follows the flags as shown below.

  | Flags | `drive_en_o` | `drive_val_o` |
  |---|---|---|
  | Only `up_o` set | 1 | 1 |
  | Only `dn_o` set | 1 | 0 |
  | Neither set, or both set | 0 | 0 |

- R6: When `mode_i[2]` is 0, `mode_i[1:0]` selects the mode.

  | `mode_i[1:0]` | Mode |
  |---|---|
  | 00 | Pass-through |
  | 01 | Released: en=0 |
  | 10 | Forced high: en=1, val=1 |
  | 11 | Forced low: en=1, val=0 |

- R7: When `mode_i[2]` is 1, `mode_i[1]` is ignored. In that case `mode_i[0]`=0 selects pass-through and `mode_i[0]`=1 selects released.
- R8: Whenever `drive_en_o` is 0, `drive_val_o` is 0.
- R9: Any mode other than pass-through clears both flags on the next clock. Edges that arrive while not in pass-through are discarded and are not acted on after the block returns to pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference pulse |
| fb_i | input | 1 | Feedback divider pulse |
| mode_i | input | 3 | Drive mode word (R6, R7) |
| drive_en_o | output | 1 | 1 = the output is driven, 0 = high impedance |
| drive_val_o | output | 1 | Driven level, valid when drive_en_o is 1 |
| up_o | output | 1 | Raw up flag |
| dn_o | output | 1 | Raw down flag |

## Verification
The bench sweeps all eight mode codes against three flag states: idle, up-only and down-only. In each case it checks the drive pair right away, and checks the flags again one clock later.

- A decoder that honoured `mode_i[1]` when `mode_i[2]` is 1 would force the line in codes 110 and 111.
- A design that kept its flags through a non-pass-through mode would leave stale pump drive behind after the block returns to pass-through.

Directed runs cover the following edge cases, each with the failure it catches:

- **Exact synchroniser latency:** a design off by one cycle would show `up_o` a cycle early or a cycle late.
- **Simultaneous edges:** a faulty design would stay latched in the both-set state or drive the pump.
- **A reference held high across a flag reset:** a level-sensitive design would set up again.
- **Edges arriving during a released mode:** a design without discard would replay them once pass-through resumes.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned N_CH   = 2;  // channel 0 = reference, 1 = feedback

  typedef enum logic [1:0] {
    DM_PASS,
    DM_HIZ,
    DM_HIGH,
    DM_LOW
  } drive_mode_e;
endpackage

// File: rtl/pfd_sync_edge.sv
module pfd_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sig_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], sig_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pfd_flags.sv
module pfd_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic ref_rise_i,
  input  logic fb_rise_i,
  output logic up_o,
  output logic dn_o
);
  logic up_q, dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (!enable_i || (up_q && dn_q)) begin
      // leaving pass-through, or coincidence reset; edges this cycle are dropped
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_q | ref_rise_i;
      dn_q <= dn_q | fb_rise_i;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;
endmodule

// File: rtl/pfd_mode_dec.sv
module pfd_mode_dec
  import pfd_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              up_i,
  input  logic              dn_i,
  output logic              pass_o,
  output logic              drive_en_o,
  output logic              drive_val_o
);
  drive_mode_e dm;

  always_comb begin
    if (mode_i[2]) begin
      dm = mode_i[0] ? DM_HIZ : DM_PASS;
    end else begin
      unique case (mode_i[1:0])
        2'b00:   dm = DM_PASS;
        2'b01:   dm = DM_HIZ;
        2'b10:   dm = DM_HIGH;
        default: dm = DM_LOW;
      endcase
    end
  end

  always_comb begin
    drive_en_o  = 1'b0;
    drive_val_o = 1'b0;
    unique case (dm)
      DM_PASS: begin
        drive_en_o  = up_i ^ dn_i;
        drive_val_o = up_i & ~dn_i;
      end
      DM_HIGH: begin
        drive_en_o  = 1'b1;
        drive_val_o = 1'b1;
      end
      DM_LOW:  drive_en_o = 1'b1;
      default: ;
    endcase
  end

  assign pass_o = (dm == DM_PASS);
endmodule

// File: rtl/pfd_ctl.sv
module pfd_ctl
  import pfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_i,
  input  logic              fb_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              drive_en_o,
  output logic              drive_val_o,
  output logic              up_o,
  output logic              dn_o
);
  logic [N_CH-1:0] pulse_in;
  logic [N_CH-1:0] rise;
  logic            pass;

  assign pulse_in = {fb_i, ref_i};

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      pfd_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sig_i  (pulse_in[c]),
        .rise_o (rise[c])
      );
    end
  endgenerate

  pfd_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (pass),
    .ref_rise_i (rise[0]),
    .fb_rise_i  (rise[1]),
    .up_o       (up_o),
    .dn_o       (dn_o)
  );

  pfd_mode_dec u_dec (
    .mode_i      (mode_i),
    .up_i        (up_o),
    .dn_i        (dn_o),
    .pass_o      (pass),
    .drive_en_o  (drive_en_o),
    .drive_val_o (drive_val_o)
  );
endmodule

// File: rtl/pfd_ctl_chk.sv
module pfd_ctl_chk
  import pfd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MODE_W-1:0] mode_i,
  input logic              up_o,
  input logic              dn_o,
  input logic              drive_en_o,
  input logic              drive_val_o
);
  logic is_pass;
  assign is_pass = (mode_i == 3'b000) || (mode_i[2] && !mode_i[0]);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!up_o && !dn_o);
    end
  end

  // R2
  up_from_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_o) |-> $past(is_pass));

  // R4
  both_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && dn_o) |=> (!up_o && !dn_o));

  // R5
  up_drives_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pass && up_o && !dn_o) |-> (drive_en_o && drive_val_o));

  // R6
  force_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b010) |-> (drive_en_o && drive_val_o));

  // R6
  force_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b011) |-> (drive_en_o && !drive_val_o));

  // R7
  upper_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[2] && mode_i[0]) |-> !drive_en_o);

  // R8
  released_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_en_o |-> !drive_val_o);

  // R9
  leave_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_pass |=> (!up_o && !dn_o));
endmodule

bind pfd_ctl pfd_ctl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .up_o        (up_o),
  .dn_o        (dn_o),
  .drive_en_o  (drive_en_o),
  .drive_val_o (drive_val_o)
);

// File: tb/pfd_ctl_tb_top.sv
`timescale 1ns/1ps
module pfd_ctl_tb_top;
  localparam int unsigned SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_i = 1'b0;
  logic       fb_i = 1'b0;
  logic [2:0] mode_i = 3'b000;
  logic       drive_en_o, drive_val_o, up_o, dn_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pfd_ctl #(.SYNC_STAGES(SYNC)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ref_i       (ref_i),
    .fb_i        (fb_i),
    .mode_i      (mode_i),
    .drive_en_o  (drive_en_o),
    .drive_val_o (drive_val_o),
    .up_o        (up_o),
    .dn_o        (dn_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  // compares {en, val, up, dn}
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    #1;
    act = {drive_en_o, drive_val_o, up_o, dn_o};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {en,val,up,dn} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    mode_i = 3'b000;
    rst_ni = 1'b0;
    step();
    rst_ni = 1'b1;
    step();
  endtask

  task automatic pulse_ref();
    ref_i = 1'b1; step(); ref_i = 1'b0;
  endtask

  task automatic pulse_fb();
    fb_i = 1'b1; step(); fb_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    step();
    chk("R1", 4'b0000);
    rst_ni = 1'b1;
    step();
    chk("R1", 4'b0000);

    // sweep of every mode code against flag state 0 = idle, 1 = up, 2 = down
    for (int code = 0; code < 8; code++) begin
      for (int st = 0; st < 3; st++) begin
        logic       pass;
        logic [1:0] fl;
        logic [1:0] drv;
        string      req;
        do_reset();
        if (st == 1) begin pulse_ref(); repeat (SYNC) step(); end
        if (st == 2) begin pulse_fb();  repeat (SYNC) step(); end
        fl   = (st == 1) ? 2'b10 : (st == 2) ? 2'b01 : 2'b00;
        pass = (code == 0) || (code[2] && !code[0]);
        if (pass)            drv = (st == 1) ? 2'b11 : (st == 2) ? 2'b10 : 2'b00;
        else if (code == 2)  drv = 2'b11;
        else if (code == 3)  drv = 2'b10;
        else                 drv = 2'b00;
        req = pass ? "R5" : (code < 4 ? "R6" : "R7");
        mode_i = code[2:0];
        chk(req, {drv, fl});
        step();
        chk(pass ? "R5" : "R9", {drv, pass ? fl : 2'b00});
      end
    end

    // R2: exact latency, then a repeated reference edge keeps up only
    do_reset();
    pulse_ref();
    repeat (SYNC - 1) step();
    chk("R2", 4'b0000);
    step();
    chk("R2", 4'b1110);
    pulse_ref();
    repeat (SYNC) step();
    chk("R2", 4'b1110);

    // R4: feedback joins, both set for one cycle, then both clear
    pulse_fb();
    repeat (SYNC) step();
    chk("R4", 4'b0011);
    step();
    chk("R4", 4'b0000);

    // R3 and R4: simultaneous edges
    ref_i = 1'b1; fb_i = 1'b1;
    step();
    ref_i = 1'b0; fb_i = 1'b0;
    repeat (SYNC) step();
    chk("R3", 4'b0011);
    step();
    chk("R4", 4'b0000);

    // R2: a held level gives no second edge after the flags clear
    ref_i = 1'b1;
    repeat (SYNC + 1) step();
    chk("R2", 4'b1110);
    pulse_fb();
    repeat (SYNC) step();
    chk("R4", 4'b0011);
    step();
    repeat (5) step();
    chk("R2", 4'b0000);
    ref_i = 1'b0;
    repeat (SYNC + 2) step();

    // R9: edges during a released mode are discarded
    mode_i = 3'b001;
    step();
    pulse_ref();
    pulse_fb();
    repeat (SYNC + 2) step();
    mode_i = 3'b000;
    chk("R9", 4'b0000);
    step();
    chk("R9", 4'b0000);

    // R3: down only drives low in code 100 (upper pass-through)
    mode_i = 3'b100;
    pulse_fb();
    repeat (SYNC) step();
    chk("R3", 4'b1001);

    done = 1'b1;
    finish_run();
  end
endmodule